// File: doc/BRIEF.md
# Large-Page NAND Command Sequencer

This block turns one command request into the sequence of control cycles that a large-page NAND device expects on its shared I/O bus. A request carries an opcode and, optionally, a column and a page. The sequencer drives one command-latch cycle, the needed address-latch cycles, and a confirm command where the operation calls for one. It keeps chip enable low through that whole burst. It then waits for the device by one of three means: a column-change delay, a write-to-busy gap followed by the ready pin or a fixed chip delay, or no wait at all. Once that wait is over it pulses `done`.

A spare-area read request is turned into an ordinary page read. The page size is added to its column. On a 16-bit bus the column is halved for every opcode that is not byte-only. Byte-only opcodes also get a single column cycle in place of two. Each control cycle lasts one clock. Every delay is given in clock cycles.

Moving data, error correction and choosing between several chips are handled elsewhere.

Top module: `nls_cmd_seq`

## Requirements
- R1: After reset the block is idle: `busy`=0, `done`=0, `ce_n`=1, `cle`=0, `ale`=0 and `io_out`=0.
- R2: A request seen while idle gives, in the next cycle, one command cycle (`cle`=1, `io_out`=opcode in bits 7:0 and zero in bits 15:8). `cle` and `ale` are never high together. A `req_valid` pulse while `busy` is high is ignored and does not change the running sequence.
- R3: Address cycles (`ale`=1, `io_out[15:8]`=0) carry these bytes in this order:
  - the column low byte;
  - the column high byte, left out for the byte-only opcodes 90h, EEh and EFh;
  - page bits 7:0, then page bits 15:8;
  - page bits 23:16, only when `cfg_row3`=1.
  A field that is not requested gives no cycles.
- R4: With `cfg_bus16`=1, the column is shifted right by one before it is sent, except for the byte-only opcodes.
- R5: With `req_spare`=1 the opcode sent is 00h and the column becomes `req_col`+`PAGE_BYTES`. The column cycles are present even when `req_has_col`=0.
- R6: A page read (00h) with at least one address cycle ends with a confirm command cycle 30h. It then waits `TWB_CYC` cycles and then for `rb_ready`.
- R7: A page read (00h) with no column and no page sends only its command cycle, with no confirm and no wait cycles.
- R8: Random data output (05h) ends with a confirm cycle E0h followed by the column-change delay. `rb_ready` has no effect on it.
- R9: Random data input (85h) sends no confirm and is followed only by the column-change delay.
- R10: The column-change delay lasts `cfg_ccs_cyc` cycles when `cfg_ccs_known`=1 and `CCS_DFLT_CYC` cycles otherwise. It lasts zero cycles when `cfg_ccs_wait`=0.
- R11: Opcodes 15h, 10h, 60h, D0h, 80h, 70h, 90h and EFh finish with no wait cycles after the last control cycle.
- R12: Every other opcode, and a read with address cycles, waits `TWB_CYC` cycles. It then waits until `rb_ready` is sampled high when `cfg_rb_present`=1, or for `CHIP_DLY_CYC` more cycles when `cfg_rb_present`=0.
- R13: `ce_n` is low on every control cycle and high on every wait and idle cycle. `done` is a one-cycle pulse in the first idle cycle after the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_opcode | input | 8 | Command opcode |
| req_spare | input | 1 | Spare-area read request |
| req_has_col | input | 1 | Column present |
| req_col | input | COL_W | Column in bytes |
| req_has_page | input | 1 | Page present |
| req_page | input | ROW_W | Page (row) address |
| cfg_bus16 | input | 1 | Device has a 16-bit bus |
| cfg_row3 | input | 1 | Three row cycles |
| cfg_ccs_wait | input | 1 | Column-change delay enabled |
| cfg_ccs_known | input | 1 | Use `cfg_ccs_cyc` in place of the default |
| cfg_ccs_cyc | input | CNT_W | Known column-change delay in cycles |
| cfg_rb_present | input | 1 | A ready/busy pin is wired |
| rb_ready | input | 1 | Ready/busy pin, high when ready |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| io_out | output | 16 | Bus value for the current cycle |

## Verification
Some rules hold on every cycle, and the bound assertions check those:
- `cle` and `ale` are never high together.
- Chip enable is low on every control cycle and high whenever the block is idle.
- Each burst opens with a command cycle.
- Address cycles keep the upper byte zero.
- `done` is a single-cycle pulse seen only while idle.

Other behaviour depends on the opcode and the configuration, and only the directed scenarios can show it. This covers the exact order and values of the address bytes, column halving, the spare-read offset, which confirm opcode is sent, and the length of each wait. Every scenario compares the whole recorded burst and the count of wait cycles against values worked out from the requirements.

// File: rtl/nls_pkg.sv
package nls_pkg;

    localparam logic [7:0] OP_READ       = 8'h00;
    localparam logic [7:0] OP_READ_GO    = 8'h30;
    localparam logic [7:0] OP_RND_OUT    = 8'h05;
    localparam logic [7:0] OP_RND_OUT_GO = 8'hE0;
    localparam logic [7:0] OP_RND_IN     = 8'h85;
    localparam logic [7:0] OP_PROG_CACHE = 8'h15;
    localparam logic [7:0] OP_PROG       = 8'h10;
    localparam logic [7:0] OP_ERASE_A    = 8'h60;
    localparam logic [7:0] OP_ERASE_B    = 8'hD0;
    localparam logic [7:0] OP_LOAD       = 8'h80;
    localparam logic [7:0] OP_STATUS     = 8'h70;
    localparam logic [7:0] OP_ID         = 8'h90;
    localparam logic [7:0] OP_FEAT_SET   = 8'hEF;
    localparam logic [7:0] OP_FEAT_GET   = 8'hEE;

    localparam int unsigned MAX_ADDR = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_CONF, ST_TWB, ST_RDY, ST_DLY
    } state_e;

    typedef enum logic [1:0] {
        POST_NONE, POST_CCS, POST_RDY
    } post_e;

    typedef struct packed {
        logic [7:0]                   op;
        logic [MAX_ADDR-1:0][7:0]     abyte;
        logic [2:0]                   acnt;
        logic                         conf_en;
        logic [7:0]                   conf_op;
        post_e                        post;
    } dec_t;

    typedef struct packed {
        state_e     st;
        dec_t       req;
        logic [2:0] idx;
        logic       done;
    } seq_t;

    function automatic logic is_byte_op(input logic [7:0] op);
        return (op == OP_ID) || (op == OP_FEAT_SET) || (op == OP_FEAT_GET);
    endfunction

    function automatic logic is_no_wait(input logic [7:0] op);
        case (op)
            OP_PROG_CACHE, OP_PROG, OP_ERASE_A, OP_ERASE_B,
            OP_LOAD, OP_STATUS, OP_ID, OP_FEAT_SET: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/nls_req_decode.sv
module nls_req_decode
    import nls_pkg::*;
#(
    parameter int unsigned COL_W      = 16,
    parameter int unsigned ROW_W      = 24,
    parameter int unsigned PAGE_BYTES = 2048
) (
    input  logic [7:0]       opcode,
    input  logic             spare,
    input  logic             has_col,
    input  logic [COL_W-1:0] col,
    input  logic             has_page,
    input  logic [ROW_W-1:0] page,
    input  logic             bus16,
    input  logic             row3,
    output dec_t             dec
);

    localparam logic [COL_W-1:0] SPARE_OFS = COL_W'(PAGE_BYTES);

    logic [7:0]       op;
    logic             col_on;
    logic             byte_op;
    logic [COL_W-1:0] colv;
    logic [15:0]      c16;
    logic [23:0]      p24;
    logic [2:0]       k;

    always_comb begin
        op      = spare ? OP_READ : opcode;
        col_on  = has_col | spare;
        byte_op = is_byte_op(op);
        colv    = spare ? (col + SPARE_OFS) : col;
        if (bus16 && !byte_op) begin
            colv = colv >> 1;
        end
        c16 = 16'(colv);
        p24 = 24'(page);

        dec       = '0;
        dec.op    = op;
        k         = 3'd0;
        if (col_on) begin
            dec.abyte[k] = c16[7:0];
            k = k + 3'd1;
            if (!byte_op) begin
                dec.abyte[k] = c16[15:8];
                k = k + 3'd1;
            end
        end
        if (has_page) begin
            dec.abyte[k] = p24[7:0];
            k = k + 3'd1;
            dec.abyte[k] = p24[15:8];
            k = k + 3'd1;
            if (row3) begin
                dec.abyte[k] = p24[23:16];
                k = k + 3'd1;
            end
        end
        dec.acnt = k;

        if (op == OP_READ) begin
            dec.conf_en = (k != 3'd0);
            dec.conf_op = OP_READ_GO;
            dec.post    = (k != 3'd0) ? POST_RDY : POST_NONE;
        end else if (op == OP_RND_OUT) begin
            dec.conf_en = 1'b1;
            dec.conf_op = OP_RND_OUT_GO;
            dec.post    = POST_CCS;
        end else if (op == OP_RND_IN) begin
            dec.post    = POST_CCS;
        end else if (is_no_wait(op)) begin
            dec.post    = POST_NONE;
        end else begin
            dec.post    = POST_RDY;
        end
    end

endmodule

// File: rtl/nls_wait_timer.sv
module nls_wait_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/nls_cmd_seq.sv
module nls_cmd_seq
    import nls_pkg::*;
#(
    parameter int unsigned COL_W        = 16,
    parameter int unsigned ROW_W        = 24,
    parameter int unsigned PAGE_BYTES   = 2048,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned TWB_CYC      = 10,
    parameter int unsigned CCS_DFLT_CYC = 50,
    parameter int unsigned CHIP_DLY_CYC = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_opcode,
    input  logic             req_spare,
    input  logic             req_has_col,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_has_page,
    input  logic [ROW_W-1:0] req_page,
    input  logic             cfg_bus16,
    input  logic             cfg_row3,
    input  logic             cfg_ccs_wait,
    input  logic             cfg_ccs_known,
    input  logic [CNT_W-1:0] cfg_ccs_cyc,
    input  logic             cfg_rb_present,
    input  logic             rb_ready,
    output logic             busy,
    output logic             done,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic [15:0]      io_out
);

    localparam logic [CNT_W-1:0] TWB_V  = CNT_W'(TWB_CYC);
    localparam logic [CNT_W-1:0] CCS_V  = CNT_W'(CCS_DFLT_CYC);
    localparam logic [CNT_W-1:0] CHIP_V = CNT_W'(CHIP_DLY_CYC);

    seq_t             q, d;
    dec_t             dec;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_tick;
    logic             t_exp;
    logic             go_post;

    nls_req_decode #(
        .COL_W      (COL_W),
        .ROW_W      (ROW_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) dec_i (
        .opcode   (req_opcode),
        .spare    (req_spare),
        .has_col  (req_has_col),
        .col      (req_col),
        .has_page (req_has_page),
        .page     (req_page),
        .bus16    (cfg_bus16),
        .row3     (cfg_row3),
        .dec      (dec)
    );

    nls_wait_timer #(
        .CNT_W (CNT_W)
    ) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .tick     (t_tick),
        .expired  (t_exp)
    );

    assign t_tick = (q.st == ST_TWB) || (q.st == ST_DLY);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        t_load  = 1'b0;
        t_val   = '0;
        go_post = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st  = ST_CMD;
                    d.req = dec;
                    d.idx = 3'd0;
                end
            end
            ST_CMD: begin
                if (q.req.acnt != 3'd0) begin
                    d.st  = ST_ADDR;
                    d.idx = 3'd0;
                end else begin
                    go_post = 1'b1;
                end
            end
            ST_ADDR: begin
                if (q.idx == (q.req.acnt - 3'd1)) begin
                    if (q.req.conf_en) begin
                        d.st = ST_CONF;
                    end else begin
                        go_post = 1'b1;
                    end
                end else begin
                    d.idx = q.idx + 3'd1;
                end
            end
            ST_CONF: begin
                go_post = 1'b1;
            end
            ST_TWB: begin
                if (t_exp) begin
                    if (cfg_rb_present) begin
                        d.st = ST_RDY;
                    end else begin
                        d.st   = ST_DLY;
                        t_load = 1'b1;
                        t_val  = CHIP_V;
                    end
                end
            end
            ST_RDY: begin
                if (rb_ready) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            ST_DLY: begin
                if (t_exp) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        if (go_post) begin
            case (q.req.post)
                POST_CCS: begin
                    if (cfg_ccs_wait) begin
                        d.st   = ST_DLY;
                        t_load = 1'b1;
                        t_val  = cfg_ccs_known ? cfg_ccs_cyc : CCS_V;
                    end else begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end
                end
                POST_RDY: begin
                    d.st   = ST_TWB;
                    t_load = 1'b1;
                    t_val  = TWB_V;
                end
                default: begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy   = (q.st != ST_IDLE);
        done   = q.done;
        cle    = (q.st == ST_CMD) || (q.st == ST_CONF);
        ale    = (q.st == ST_ADDR);
        ce_n   = !(cle || ale);
        io_out = 16'h0000;
        case (q.st)
            ST_CMD:  io_out = {8'h00, q.req.op};
            ST_ADDR: io_out = {8'h00, q.req.abyte[q.idx]};
            ST_CONF: io_out = {8'h00, q.req.conf_op};
            default: io_out = 16'h0000;
        endcase
    end

endmodule

// File: rtl/nls_cmd_seq_chk.sv
module nls_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        ce_n,
    input logic        cle,
    input logic        ale,
    input logic [15:0] io_out
);

    a_r2_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    a_r2_burst_opens_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce_n) |-> cle);

    a_r3_addr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (io_out[15:8] == 8'h00));

    a_r13_ce_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (cle || ale) |-> !ce_n);

    a_r13_ce_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ce_n);

    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r13_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cle && !ale && io_out == 16'h0000));

endmodule

bind nls_cmd_seq nls_cmd_seq_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .ce_n   (ce_n),
    .cle    (cle),
    .ale    (ale),
    .io_out (io_out)
);

// File: tb/nls_cmd_seq_tb.sv
`timescale 1ns/1ps
module nls_cmd_seq_tb_top;

    localparam int TWB   = 10;
    localparam int CCSD  = 50;
    localparam int CHIP  = 2000;
    localparam int PAGEB = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_opcode = 8'h00;
    logic        req_spare = 1'b0;
    logic        req_has_col = 1'b0;
    logic [15:0] req_col = 16'h0;
    logic        req_has_page = 1'b0;
    logic [23:0] req_page = 24'h0;
    logic        cfg_bus16 = 1'b0;
    logic        cfg_row3 = 1'b0;
    logic        cfg_ccs_wait = 1'b1;
    logic        cfg_ccs_known = 1'b0;
    logic [15:0] cfg_ccs_cyc = 16'd0;
    logic        cfg_rb_present = 1'b1;
    logic        rb_ready = 1'b1;
    logic        busy, done, ce_n, cle, ale;
    logic [15:0] io_out;

    int n_chk = 0;
    int n_fail = 0;

    logic [16:0] exp_v [0:11];
    logic [16:0] rec_v [0:11];
    int exp_n, rec_n, post_n;
    logic ce_bad;

    always #5 clk = ~clk;

    nls_cmd_seq #(
        .PAGE_BYTES(PAGEB), .TWB_CYC(TWB), .CCS_DFLT_CYC(CCSD), .CHIP_DLY_CYC(CHIP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_spare(req_spare), .req_has_col(req_has_col), .req_col(req_col),
        .req_has_page(req_has_page), .req_page(req_page), .cfg_bus16(cfg_bus16),
        .cfg_row3(cfg_row3), .cfg_ccs_wait(cfg_ccs_wait), .cfg_ccs_known(cfg_ccs_known),
        .cfg_ccs_cyc(cfg_ccs_cyc), .cfg_rb_present(cfg_rb_present), .rb_ready(rb_ready),
        .busy(busy), .done(done), .ce_n(ce_n), .cle(cle), .ale(ale), .io_out(io_out)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        summary();
    end

    task automatic exp_clear();
        exp_n = 0;
    endtask

    task automatic exp_c(input logic [7:0] b);
        exp_v[exp_n] = {1'b1, 8'h00, b};
        exp_n++;
    endtask

    task automatic exp_a(input logic [7:0] b);
        exp_v[exp_n] = {1'b0, 8'h00, b};
        exp_n++;
    endtask

    // Issue one request, record the burst and the number of wait cycles.
    task automatic run(input logic [7:0] op, input logic sp, input logic hc,
                       input logic [15:0] c, input logic hp, input logic [23:0] p,
                       input int hold, input logic pulse);
        int guard;
        logic pulsed;
        rec_n = 0; post_n = 0; ce_bad = 1'b0; guard = 0; pulsed = 1'b0;
        @(negedge clk);
        req_opcode = op; req_spare = sp; req_has_col = hc; req_col = c;
        req_has_page = hp; req_page = p; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (cle || ale) begin
                if (rec_n < 12) rec_v[rec_n] = {cle, io_out};
                rec_n++;
                if (ce_n) ce_bad = 1'b1;
            end else if (busy) begin
                post_n++;
                if (!ce_n) ce_bad = 1'b1;
                if (hold > 0 && post_n == hold) rb_ready = 1'b1;
            end
            if (pulse && !pulsed) begin
                req_valid = 1'b1; req_opcode = 8'h90; req_has_col = 1'b0;
                req_has_page = 1'b0; req_spare = 1'b0; pulsed = 1'b1;
            end else begin
                req_valid = 1'b0;
            end
            if (done) break;
            guard++;
            if (guard > 20000) break;
            @(negedge clk);
        end
        chk(done, "R13 sequence ends with done", int'(done), 1);
        chk(!busy, "R13 idle on done", int'(busy), 0);
        @(negedge clk);
        chk(!done, "R13 done lasts one cycle", int'(done), 0);
        chk(!ce_bad, "R13 ce_n low only on control cycles", int'(ce_bad), 0);
    endtask

    task automatic check_burst(input string tag, input int exp_post);
        chk(rec_n == exp_n, tag, rec_n, exp_n);
        for (int i = 0; i < exp_n && i < rec_n && i < 12; i++) begin
            chk(rec_v[i] == exp_v[i], tag, int'(rec_v[i]), int'(exp_v[i]));
        end
        chk(post_n == exp_post, tag, post_n, exp_post);
    endtask

    task automatic t_reset();
        chk(!busy && !done && ce_n && !cle && !ale && io_out == 16'h0,
            "R1 reset state", int'({busy, done, ce_n, cle, ale}), 5'b00100);
    endtask

    task automatic t_read_full();
        cfg_row3 = 1'b1; cfg_bus16 = 1'b0;
        run(8'h00, 1'b0, 1'b1, 16'h0123, 1'b1, 24'h012345, 0, 1'b0);
        exp_clear(); exp_c(8'h00); exp_a(8'h23); exp_a(8'h01); exp_a(8'h45);
        exp_a(8'h23); exp_a(8'h01); exp_c(8'h30);
        check_burst("R3 R6 R12 read with three row cycles", TWB + 1);
    endtask

    task automatic t_read_bus16();
        cfg_row3 = 1'b0; cfg_bus16 = 1'b1;
        run(8'h00, 1'b0, 1'b1, 16'h0246, 1'b1, 24'h002345, 0, 1'b0);
        exp_clear(); exp_c(8'h00); exp_a(8'h23); exp_a(8'h01); exp_a(8'h45);
        exp_a(8'h23); exp_c(8'h30);
        check_burst("R4 halved column on 16-bit bus", TWB + 1);
    endtask

    task automatic t_byte_op();
        cfg_bus16 = 1'b1;
        run(8'h90, 1'b0, 1'b1, 16'h0040, 1'b0, 24'h0, 0, 1'b0);
        exp_clear(); exp_c(8'h90); exp_a(8'h40);
        check_burst("R3 R4 R11 byte-only opcode single column cycle", 0);
        cfg_bus16 = 1'b0;
    endtask

    task automatic t_spare();
        cfg_row3 = 1'b0;
        run(8'h50, 1'b1, 1'b0, 16'h0010, 1'b1, 24'h000007, 0, 1'b0);
        exp_clear(); exp_c(8'h00); exp_a(8'h10); exp_a(8'h08); exp_a(8'h07);
        exp_a(8'h00); exp_c(8'h30);
        check_burst("R5 spare read becomes offset page read", TWB + 1);
    endtask

    task automatic t_read_bare();
        run(8'h00, 1'b0, 1'b0, 16'h0, 1'b0, 24'h0, 0, 1'b0);
        exp_clear(); exp_c(8'h00);
        check_burst("R7 bare read no confirm no wait", 0);
    endtask

    task automatic t_rnd_out();
        cfg_ccs_known = 1'b1; cfg_ccs_cyc = 16'd7; rb_ready = 1'b0;
        run(8'h05, 1'b0, 1'b1, 16'h0200, 1'b0, 24'h0, 0, 1'b0);
        exp_clear(); exp_c(8'h05); exp_a(8'h00); exp_a(8'h02); exp_c(8'hE0);
        check_burst("R8 R10 random output confirm and known delay", 7);
        rb_ready = 1'b1; cfg_ccs_known = 1'b0;
    endtask

    task automatic t_rnd_in();
        run(8'h85, 1'b0, 1'b1, 16'h0003, 1'b0, 24'h0, 0, 1'b0);
        exp_clear(); exp_c(8'h85); exp_a(8'h03); exp_a(8'h00);
        check_burst("R9 R10 random input default delay", CCSD);
        cfg_ccs_wait = 1'b0;
        run(8'h85, 1'b0, 1'b1, 16'h0003, 1'b0, 24'h0, 0, 1'b0);
        check_burst("R10 delay skipped when disabled", 0);
        cfg_ccs_wait = 1'b1;
    endtask

    task automatic t_no_wait();
        logic [7:0] ops [0:7];
        ops[0] = 8'h15; ops[1] = 8'h10; ops[2] = 8'h60; ops[3] = 8'hD0;
        ops[4] = 8'h80; ops[5] = 8'h70; ops[6] = 8'h90; ops[7] = 8'hEF;
        rb_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            run(ops[i], 1'b0, 1'b0, 16'h0, 1'b0, 24'h0, 0, 1'b0);
            exp_clear(); exp_c(ops[i]);
            check_burst("R11 no-wait opcode", 0);
        end
        rb_ready = 1'b1;
    endtask

    task automatic t_ready_wait();
        cfg_rb_present = 1'b1; rb_ready = 1'b0;
        run(8'hFF, 1'b0, 1'b0, 16'h0, 1'b0, 24'h0, TWB + 20, 1'b1);
        exp_clear(); exp_c(8'hFF);
        check_burst("R12 R2 ready wait and ignored request while busy", TWB + 20);
        rb_ready = 1'b1;
    endtask

    task automatic t_chip_delay();
        cfg_rb_present = 1'b0;
        run(8'hFF, 1'b0, 1'b0, 16'h0, 1'b0, 24'h0, 0, 1'b0);
        exp_clear(); exp_c(8'hFF);
        check_burst("R12 fixed chip delay without ready pin", TWB + CHIP);
        cfg_rb_present = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_full();
        t_read_bus16();
        t_byte_op();
        t_spare();
        t_read_bare();
        t_rnd_out();
        t_rnd_in();
        t_no_wait();
        t_ready_wait();
        t_chip_delay();
        summary();
    end

endmodule